// File: doc/BRIEF.md
# Delayed-Branch Pipeline Sequencer

This block steers a short in-order pipeline for a processor whose instructions all have the same length. Each cycle it looks at the instruction that has been decoded and decides whether that instruction may enter its execute phase. While one instruction executes, the next one is fetched. Loads and stores also occupy a memory phase after execute. The block produces the fetch address, the phase enables and a stall indication. The datapath, the register file and the memory are outside it.

Control flow uses a single delay slot. The instruction after a branch always executes, and a taken branch only changes the fetch address once that slot instruction has issued. Nothing is ever flushed. A load reserves its destination register. Later instructions keep issuing until one of them names a reserved register as a source, and that instruction then waits until the load writes its data back. A memory phase that is waiting for memory freezes the whole pipe.

Top module: `pipe_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`, asynchronous) sets `pc` to 0, empties the memory phase (`mem_en` low), releases every register reservation and drops any pending branch redirect. The first instruction after reset issues without waiting, and the second sees `pc` equal to 1.
- R2: In a cycle with no stall, `fetch_en` is 1, `stall` is 0 and `pc` rises by one in the next cycle, unless R6 applies. `exec_en` is 1 in that cycle for every class except NOP. Class codes on `instr_class` are: 0 NOP, 1 ALU, 2 LOAD, 3 STORE, 4 BRANCH; any other code behaves as NOP.
- R3: ALU, BRANCH and NOP instructions use only the fetch and execute phases, so issuing one of them opens no memory phase.
- R4: A LOAD or STORE that issues has `mem_en` high from the next cycle on, until and including the first cycle in which `mem_ready` is high.
- R5: While `mem_en` is high and `mem_ready` is low, `stall` is 1, `fetch_en` and `exec_en` are 0, and `pc` holds.
- R6: A BRANCH with `br_taken` set records `br_target`. The next instruction to issue is its delay slot and executes normally, and the cycle after that slot issues shows `pc` equal to the recorded target.
- R7: A BRANCH with `br_taken` clear still has a delay slot, and `pc` keeps counting up by one through the slot and after it.
- R8: A BRANCH that issues in a delay slot drives `illegal_seq` to 1 in its issue cycle. Its taken flag and target are ignored, and it opens no new delay slot.
- R9: An issued LOAD reserves register `dst_reg`. An instruction that reads a reserved register stalls: ALU and STORE read `src_a` and `src_b`, LOAD and BRANCH read `src_a`. An instruction that reads no reserved register issues as soon as memory allows.
- R10: A reservation is released in the cycle the load completes (`mem_en` and `mem_ready` both high). An instruction waiting on that register issues in the cycle after.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_class | input | 3 | Class of the decoded instruction |
| dst_reg | input | RW | Destination register number |
| src_a | input | RW | First source register number |
| src_b | input | RW | Second source register number |
| br_target | input | PW | Branch target address |
| br_taken | input | 1 | Branch condition is true |
| mem_ready | input | 1 | Memory finishes the current transfer this cycle |
| pc | output | PW | Current fetch address |
| fetch_en | output | 1 | Fetch the next instruction (pipe advances) |
| exec_en | output | 1 | Decoded instruction enters execute |
| mem_en | output | 1 | Memory phase active this cycle |
| stall | output | 1 | Decoded instruction is held |
| illegal_seq | output | 1 | Branch found in a delay slot |

## Verification
The bound checker tests these rules on every cycle:
- the address step after an unstalled cycle;
- the held address during a stall;
- the jump to the recorded target after a taken delay slot, and the plain step after a not-taken slot;
- the memory phase following each load or store, and none following the other classes;
- the freeze while memory is not ready;
- the rule that `illegal_seq` only rises in a delay-slot issue.

Only the bench scenarios can show the rest:
- the reset values;
- register reservations, which stall a dependent reader, let an independent one through and release in the completion cycle;
- the discarding of a pending redirect and a reservation by a mid-run reset.

// File: rtl/pipe_ctrl_pkg.sv
package pipe_ctrl_pkg;

    typedef enum logic [2:0] {
        CL_NOP    = 3'd0,
        CL_ALU    = 3'd1,
        CL_LOAD   = 3'd2,
        CL_STORE  = 3'd3,
        CL_BRANCH = 3'd4
    } iclass_e;

    // first source operand is read by ALU, LOAD, STORE and BRANCH
    function automatic logic uses_src_a(input logic [2:0] c);
        return (c == CL_ALU) || (c == CL_LOAD) || (c == CL_STORE) || (c == CL_BRANCH);
    endfunction

    // second source operand is read by ALU and STORE only
    function automatic logic uses_src_b(input logic [2:0] c);
        return (c == CL_ALU) || (c == CL_STORE);
    endfunction

endpackage

// File: rtl/pc_branch_unit.sv
module pc_branch_unit #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          is_branch,
    input  logic          br_taken,
    input  logic [PW-1:0] br_target,
    output logic [PW-1:0] pc,
    output logic          slot_q,
    output logic          redir_q,
    output logic [PW-1:0] tgt_q,
    output logic          illegal
);
    typedef struct packed {
        logic [PW-1:0] pc;
        logic          slot;
        logic          redir;
        logic [PW-1:0] tgt;
    } br_state_t;

    br_state_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        illegal = advance && st_q.slot && is_branch;
        if (advance) begin
            if (st_q.slot) begin
                // delay slot issues now: apply or drop the recorded redirect
                st_d.pc    = st_q.redir ? st_q.tgt : st_q.pc + PW'(1);
                st_d.slot  = 1'b0;
                st_d.redir = 1'b0;
            end else begin
                st_d.pc = st_q.pc + PW'(1);
                if (is_branch) begin
                    st_d.slot  = 1'b1;
                    st_d.redir = br_taken;
                    st_d.tgt   = br_target;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pc      = st_q.pc;
    assign slot_q  = st_q.slot;
    assign redir_q = st_q.redir;
    assign tgt_q   = st_q.tgt;
endmodule

// File: rtl/mem_phase_unit.sv
module mem_phase_unit #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          advance,
    input  logic          is_mem,
    input  logic          is_load,
    input  logic [RW-1:0] dst,
    input  logic          mem_ready,
    output logic          busy,
    output logic          mem_stall,
    output logic          wb_valid,
    output logic [RW-1:0] wb_reg
);
    typedef struct packed {
        logic          valid;
        logic          load;
        logic [RW-1:0] dst;
    } mp_state_t;

    mp_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.valid && mem_ready) st_d.valid = 1'b0;
        if (advance && is_mem) begin
            st_d.valid = 1'b1;
            st_d.load  = is_load;
            st_d.dst   = dst;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.valid;
    assign mem_stall = st_q.valid && !mem_ready;
    assign wb_valid  = st_q.valid && mem_ready && st_q.load;
    assign wb_reg    = st_q.dst;
endmodule

// File: rtl/reg_lock_table.sv
module reg_lock_table #(
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          set_en,
    input  logic [RW-1:0] set_reg,
    input  logic          clr_en,
    input  logic [RW-1:0] clr_reg,
    input  logic          rd_a_en,
    input  logic [RW-1:0] rd_a,
    input  logic          rd_b_en,
    input  logic [RW-1:0] rd_b,
    output logic          hazard
);
    localparam int NREG = 1 << RW;

    logic [NREG-1:0] lock_d, lock_q;

    // one reservation bit per register; set wins over clear for the same register
    for (genvar g = 0; g < NREG; g++) begin : g_bit
        always_comb begin
            lock_d[g] = lock_q[g];
            if (clr_en && (clr_reg == RW'(g))) lock_d[g] = 1'b0;
            if (set_en && (set_reg == RW'(g))) lock_d[g] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lock_q <= '0;
        else        lock_q <= lock_d;
    end

    assign hazard = (rd_a_en && lock_q[rd_a]) || (rd_b_en && lock_q[rd_b]);
endmodule

// File: rtl/pipe_ctrl.sv
module pipe_ctrl
    import pipe_ctrl_pkg::*;
#(
    parameter int PW = 8,
    parameter int RW = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    instr_class,
    input  logic [RW-1:0] dst_reg,
    input  logic [RW-1:0] src_a,
    input  logic [RW-1:0] src_b,
    input  logic [PW-1:0] br_target,
    input  logic          br_taken,
    input  logic          mem_ready,
    output logic [PW-1:0] pc,
    output logic          fetch_en,
    output logic          exec_en,
    output logic          mem_en,
    output logic          stall,
    output logic          illegal_seq
);
    logic          is_load, is_store, is_branch, is_nop;
    logic          hazard, mem_stall, advance;
    logic          wb_valid;
    logic [RW-1:0] wb_reg;
    logic          slot_q, redir_q;
    logic [PW-1:0] tgt_q;

    assign is_load   = (instr_class == CL_LOAD);
    assign is_store  = (instr_class == CL_STORE);
    assign is_branch = (instr_class == CL_BRANCH);
    assign is_nop    = !(uses_src_a(instr_class));

    assign advance     = !mem_stall && !hazard;
    assign fetch_en    = advance;
    assign stall       = !advance;
    assign exec_en     = advance && !is_nop;

    reg_lock_table #(.RW(RW)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (advance && is_load),
        .set_reg (dst_reg),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .rd_a_en (uses_src_a(instr_class)),
        .rd_a    (src_a),
        .rd_b_en (uses_src_b(instr_class)),
        .rd_b    (src_b),
        .hazard  (hazard)
    );

    mem_phase_unit #(.RW(RW)) u_mem (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .is_mem    (is_load || is_store),
        .is_load   (is_load),
        .dst       (dst_reg),
        .mem_ready (mem_ready),
        .busy      (mem_en),
        .mem_stall (mem_stall),
        .wb_valid  (wb_valid),
        .wb_reg    (wb_reg)
    );

    pc_branch_unit #(.PW(PW)) u_br (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance   (advance),
        .is_branch (is_branch),
        .br_taken  (br_taken),
        .br_target (br_target),
        .pc        (pc),
        .slot_q    (slot_q),
        .redir_q   (redir_q),
        .tgt_q     (tgt_q),
        .illegal   (illegal_seq)
    );
endmodule

// File: rtl/pipe_ctrl_chk.sv
module pipe_ctrl_chk
    import pipe_ctrl_pkg::*;
#(
    parameter int PW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    instr_class,
    input logic          mem_ready,
    input logic [PW-1:0] pc,
    input logic          fetch_en,
    input logic          mem_en,
    input logic          stall,
    input logic          illegal_seq,
    input logic          slot_q,
    input logic          redir_q,
    input logic [PW-1:0] tgt_q
);
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !slot_q) |=> (pc == $past(pc) + PW'(1)));

    p_no_mem_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && !mem_en && (instr_class != CL_LOAD) && (instr_class != CL_STORE)) |=> !mem_en);

    p_mem_phase_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && ((instr_class == CL_LOAD) || (instr_class == CL_STORE))) |=> mem_en);

    p_mem_freeze_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_ready) |-> stall);

    p_pc_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        stall |=> $stable(pc));

    p_redirect_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && slot_q && redir_q) |=> (pc == $past(tgt_q)));

    p_not_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_en && slot_q && !redir_q) |=> (pc == $past(pc) + PW'(1)));

    p_illegal_r8: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_seq |-> (slot_q && fetch_en));
endmodule

bind pipe_ctrl pipe_ctrl_chk #(.PW(PW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .instr_class (instr_class),
    .mem_ready   (mem_ready),
    .pc          (pc),
    .fetch_en    (fetch_en),
    .mem_en      (mem_en),
    .stall       (stall),
    .illegal_seq (illegal_seq),
    .slot_q      (slot_q),
    .redir_q     (redir_q),
    .tgt_q       (tgt_q)
);

// File: tb/sim_pipe_ctrl.sv
`timescale 1ns/1ps
module sim_pipe_ctrl;
    localparam int PW = 8;
    localparam int RW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [2:0]    instr_class = 3'd0;
    logic [RW-1:0] dst_reg = '0, src_a = '0, src_b = '0;
    logic [PW-1:0] br_target = '0;
    logic          br_taken = 1'b0, mem_ready = 1'b1;
    logic [PW-1:0] pc;
    logic          fetch_en, exec_en, mem_en, stall, illegal_seq;

    always #10 clk = ~clk;

    pipe_ctrl #(.PW(PW), .RW(RW)) u0 (
        .clk(clk), .rst_n(rst_n), .instr_class(instr_class), .dst_reg(dst_reg),
        .src_a(src_a), .src_b(src_b), .br_target(br_target), .br_taken(br_taken),
        .mem_ready(mem_ready), .pc(pc), .fetch_en(fetch_en), .exec_en(exec_en),
        .mem_en(mem_en), .stall(stall), .illegal_seq(illegal_seq)
    );

    typedef struct {
        logic [PW-1:0] pc;
        logic          f, e, m, il;
        string         req;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // driver: apply one cycle of stimulus just after the edge and queue the expectation
    task automatic step(input bit rs, input logic [2:0] c, input int d, input int a, input int b,
                        input int tgt, input bit tk, input bit rdy,
                        input int epc, input bit ef, input bit ee, input bit em, input bit eil,
                        input string req);
        exp_t x;
        @(posedge clk);
        #2;
        rst_n = rs; instr_class = c; dst_reg = RW'(d); src_a = RW'(a); src_b = RW'(b);
        br_target = PW'(tgt); br_taken = tk; mem_ready = rdy;
        x.pc = PW'(epc); x.f = ef; x.e = ee; x.m = em; x.il = eil; x.req = req;
        exp_q.push_back(x);
    endtask

    // monitor: compare mid-cycle
    initial begin
        forever begin
            @(negedge clk);
            if (exp_q.size() > 0) begin
                exp_t x;
                x = exp_q.pop_front();
                n_chk++;
                if (pc !== x.pc || fetch_en !== x.f || stall !== !x.f || exec_en !== x.e ||
                    mem_en !== x.m || illegal_seq !== x.il) begin
                    n_fail++;
                    $display("FAIL %s: pc=%0h fetch=%0b stall=%0b exec=%0b mem=%0b ill=%0b expected pc=%0h fetch=%0b stall=%0b exec=%0b mem=%0b ill=%0b",
                             x.req, pc, fetch_en, stall, exec_en, mem_en, illegal_seq,
                             x.pc, x.f, !x.f, x.e, x.m, x.il);
                end
            end
        end
    end

    initial begin
        // reset state: R1
        step(0, 3'd0, 0, 0, 0, 0, 0, 1,   'h00, 1, 0, 0, 0, "R1");
        // plain issue: R2, R3
        step(1, 3'd1, 1, 2, 3, 0, 0, 1,   'h00, 1, 1, 0, 0, "R2");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1,   'h01, 1, 0, 0, 0, "R2");
        // store then memory wait: R4, R5
        step(1, 3'd3, 0, 4, 5, 0, 0, 0,   'h02, 1, 1, 0, 0, "R4");
        step(1, 3'd1, 6, 7, 8, 0, 0, 0,   'h03, 0, 0, 1, 0, "R5");
        step(1, 3'd1, 6, 7, 8, 0, 0, 0,   'h03, 0, 0, 1, 0, "R5");
        step(1, 3'd1, 6, 7, 8, 0, 0, 1,   'h03, 1, 1, 1, 0, "R4");
        // taken branch with delay slot: R3, R6
        step(1, 3'd4, 0, 9, 0, 'h40, 1, 1, 'h04, 1, 1, 0, 0, "R3");
        step(1, 3'd1, 1, 2, 3, 0, 0, 1,   'h05, 1, 1, 0, 0, "R6");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1,   'h40, 1, 0, 0, 0, "R6");
        // branch in a delay slot: R8
        step(1, 3'd4, 0, 0, 0, 'h80, 1, 1, 'h41, 1, 1, 0, 0, "R6");
        step(1, 3'd4, 0, 0, 0, 'h20, 1, 1, 'h42, 1, 1, 0, 1, "R8");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1,   'h80, 1, 0, 0, 0, "R8");
        // not-taken branch: R7
        step(1, 3'd4, 0, 0, 0, 'h10, 0, 1, 'h81, 1, 1, 0, 0, "R8");
        step(1, 3'd1, 1, 2, 3, 0, 0, 1,   'h82, 1, 1, 0, 0, "R7");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1,   'h83, 1, 0, 0, 0, "R7");
        // load-use interlock: R9, R10
        step(1, 3'd2, 10, 11, 0, 0, 0, 1, 'h84, 1, 1, 0, 0, "R9");
        step(1, 3'd1, 12, 10, 14, 0, 0, 1,'h85, 0, 0, 1, 0, "R9");
        step(1, 3'd1, 12, 10, 14, 0, 0, 1,'h85, 1, 1, 0, 0, "R10");
        step(1, 3'd2, 10, 11, 0, 0, 0, 1, 'h86, 1, 1, 0, 0, "R9");
        step(1, 3'd1, 12, 13, 14, 0, 0, 1,'h87, 1, 1, 1, 0, "R9");
        step(1, 3'd3, 0, 10, 10, 0, 0, 1, 'h88, 1, 1, 0, 0, "R10");
        step(1, 3'd2, 3, 4, 0, 0, 0, 1,   'h89, 1, 1, 1, 0, "R4");
        step(1, 3'd4, 0, 3, 0, 'h10, 1, 1,'h8A, 0, 0, 1, 0, "R9");
        step(1, 3'd4, 0, 3, 0, 'h10, 1, 1,'h8A, 1, 1, 0, 0, "R10");
        step(1, 3'd2, 5, 6, 0, 0, 0, 0,   'h8B, 1, 1, 0, 0, "R6");
        // mid-run reset discards lock, memory phase and redirect: R1
        step(0, 3'd0, 0, 0, 0, 0, 0, 0,   'h00, 1, 0, 0, 0, "R1");
        step(1, 3'd1, 1, 5, 5, 0, 0, 0,   'h00, 1, 1, 0, 0, "R1");
        step(1, 3'd0, 0, 0, 0, 0, 0, 1,   'h01, 1, 0, 0, 0, "R1");
        @(negedge clk);
        @(negedge clk);
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule